// File: doc/BRIEF.md
# Self-Aligning Serial-to-Parallel Converter

This block turns a fast serial bit stream into parallel words of `WIDTH` bits (six by default). Bits are shifted in on the fast clock. Complete words are presented on the divided clock, which runs at one `WIDTH`-th of the fast rate with its rising edges on fast rising edges. The word boundary is not fixed. Each slip request moves it one serial bit later in the stream, so the word grid can be turned to any of the `WIDTH` positions.

The slip requests come from a small alignment controller in the divided-clock domain. While its enable is high, it watches one bit of the parallel word, by default bit 1. The transmitter repeats a training word in which only that bit is set. Whenever the watched bit is wrong, the controller fires a one-cycle slip pulse. After each pulse it waits long enough for the moved boundary to appear at the output. After a run of correct words, it raises an aligned flag and stops acting, so ordinary data can follow without disturbing the boundary. Lowering the enable clears the flag and the controller's internal state.

Top module: `deser_align`

## Requirements
- R1: The serial bit received first in a word appears on `par_out[0]` and the last on `par_out[WIDTH-1]`. A word sent least-significant bit first therefore arrives with its value unchanged.
- R2: Each slip pulse makes the word boundary one serial bit later. Data delayed by one bit is realigned with exactly one pulse. Data advanced by one bit needs exactly `WIDTH-1` pulses, because `WIDTH` slips return to the same boundary.
- R3: `bitslip` is never high for two divided-clock cycles in a row.
- R4: After every slip pulse, `bitslip` stays low for at least `SLIP_GAP` (default 2) divided-clock cycles.
- R5: With `sync_en` high and `aligned` low, a slip is issued whenever `par_out[WATCH_BIT]` (bit 1) differs from `WATCH_VAL` (1). The training word is 6'b000010. Starting from any boundary, at most `WIDTH-1` pulses reach alignment.
- R6: `aligned` rises after `MATCH_N` (default 4) consecutive divided-clock cycles in which the watched bit is correct. If the stream is already aligned when `sync_en` rises, this takes exactly `MATCH_N` cycles with no slip.
- R7: While `aligned` is high, no slip is issued whatever the data, and data words pass unchanged.
- R8: One divided-clock cycle after `sync_en` is sampled low, `aligned` is low. No slip is issued while `sync_en` stays low, even when the stream is misaligned.
- R9: While reset is held, `par_out`, `aligned` and `bitslip` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Serial bit clock |
| clk_div | input | 1 | Word clock, fast clock divided by WIDTH, rising edges on fast rising edges |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| ser_in | input | 1 | Serial data, sampled on the fast clock |
| sync_en | input | 1 | Enables the alignment controller (divided domain) |
| par_out | output | WIDTH | Parallel word (divided domain) |
| aligned | output | 1 | Alignment reached and held |
| bitslip | output | 1 | Slip pulse sent to the converter, one divided cycle wide |

## Verification
The bench shifts the stream by one bit in each direction while the controller is disabled, then counts the pulses needed to realign. A converter that slipped the wrong way, or by more than one bit, would need five pulses where one is expected, or one where five are expected. A controller that re-checked too soon would see a stale word and fire extra pulses; the bench catches this through the minimum spacing and the exact pulse count. The bench also times `aligned` from the rise of enable to catch an off-by-one in the match counter. It sends differing data after alignment to show that a design which kept watching would slip and corrupt the word sequence.

// File: rtl/deser_align_pkg.sv
package deser_align_pkg;

    // Decision taken by the alignment controller on each divided clock
    typedef enum logic [2:0] {
        ACT_OFF,    // disabled, clear everything
        ACT_HOLD,   // aligned, keep state
        ACT_WAIT,   // settling after a slip
        ACT_SLIP,   // watched bit wrong, move boundary
        ACT_MATCH   // watched bit right, count it
    } sync_act_e;

endpackage

// File: rtl/deser_slip_xfer.sv
module deser_slip_xfer (
    input  logic clk_fast,
    input  logic rst_n,
    input  logic slip_div,
    output logic slip_take
);

    typedef struct packed {
        logic meta;
        logic seen;
    } xfer_t;

    xfer_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = slip_div;
        st_d.seen = st_q.meta;
    end

    always_ff @(posedge clk_fast or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // one fast-cycle request per divided-clock pulse
    assign slip_take = st_q.meta & ~st_q.seen;

    a_r3_take_single: assert property (@(posedge clk_fast) disable iff (!rst_n)
        slip_take |=> !slip_take);

endmodule

// File: rtl/deser_shift.sv
module deser_shift #(
    parameter int WIDTH = 6
) (
    input  logic             clk_fast,
    input  logic             rst_n,
    input  logic             ser_in,
    input  logic             slip_take,
    output logic [WIDTH-1:0] word_o
);

    localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    typedef struct packed {
        logic [WIDTH-2:0] sh;
        logic [CW-1:0]    cnt;
        logic [WIDTH-1:0] word;
    } shift_t;

    shift_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.sh = {ser_in, st_q.sh[WIDTH-2:1]};
        if (slip_take) begin
            st_d.cnt = st_q.cnt;                 // boundary moves one bit later
        end else if (st_q.cnt == LAST) begin
            st_d.cnt  = '0;
            st_d.word = {ser_in, st_q.sh};       // oldest bit lands at bit 0
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_fast or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_o = st_q.word;

    a_r2_slip_holds_count: assert property (@(posedge clk_fast) disable iff (!rst_n)
        slip_take |=> (st_q.cnt == $past(st_q.cnt)));

    a_r1_cnt_in_range: assert property (@(posedge clk_fast) disable iff (!rst_n)
        st_q.cnt <= LAST);

    a_r1_word_on_wrap: assert property (@(posedge clk_fast) disable iff (!rst_n)
        !$stable(st_q.word) |-> ($past(st_q.cnt) == LAST && !$past(slip_take)));

endmodule

// File: rtl/deser_word_out.sv
module deser_word_out #(
    parameter int WIDTH = 6
) (
    input  logic             clk_div,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] word_i,
    output logic [WIDTH-1:0] par_o
);

    logic [WIDTH-1:0] par_d, par_q;

    always_comb par_d = word_i;

    always_ff @(posedge clk_div or negedge rst_n) begin
        if (!rst_n) par_q <= '0;
        else        par_q <= par_d;
    end

    assign par_o = par_q;

endmodule

// File: rtl/deser_align_sync.sv
module deser_align_sync
    import deser_align_pkg::*;
#(
    parameter logic WATCH_VAL = 1'b1,
    parameter int   SLIP_GAP  = 2,
    parameter int   MATCH_N   = 4
) (
    input  logic clk_div,
    input  logic rst_n,
    input  logic en,
    input  logic watch_bit,
    output logic slip_o,
    output logic aligned_o
);

    localparam int GW = $clog2(SLIP_GAP + 1);
    localparam int MW = $clog2(MATCH_N + 1);
    localparam logic [GW-1:0] GAP_LOAD  = GW'(SLIP_GAP);
    localparam logic [MW-1:0] MATCH_TOP = MW'(MATCH_N - 1);

    typedef struct packed {
        logic [GW-1:0] gap;
        logic [MW-1:0] match;
        logic          aligned;
        logic          slip;
    } sync_t;

    sync_t     st_d, st_q;
    sync_act_e act;

    always_comb begin
        if (!en)                        act = ACT_OFF;
        else if (st_q.aligned)          act = ACT_HOLD;
        else if (st_q.gap != '0)        act = ACT_WAIT;
        else if (watch_bit != WATCH_VAL) act = ACT_SLIP;
        else                            act = ACT_MATCH;
    end

    always_comb begin
        st_d      = st_q;
        st_d.slip = 1'b0;
        case (act)
            ACT_OFF:   st_d = '0;
            ACT_HOLD:  ;
            ACT_WAIT:  st_d.gap = st_q.gap - 1'b1;
            ACT_SLIP: begin
                st_d.slip  = 1'b1;
                st_d.gap   = GAP_LOAD;
                st_d.match = '0;
            end
            ACT_MATCH: begin
                if (st_q.match == MATCH_TOP) begin
                    st_d.aligned = 1'b1;
                    st_d.match   = '0;
                end else begin
                    st_d.match = st_q.match + 1'b1;
                end
            end
            default:   st_d = '0;
        endcase
    end

    always_ff @(posedge clk_div or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign slip_o    = st_q.slip;
    assign aligned_o = st_q.aligned;

    a_r3_pulse_one_cycle: assert property (@(posedge clk_div) disable iff (!rst_n)
        slip_o |=> !slip_o);

    a_r4_gap_after_slip: assert property (@(posedge clk_div) disable iff (!rst_n)
        $past(slip_o, 2) |-> !slip_o);

    a_r8_quiet_when_off: assert property (@(posedge clk_div) disable iff (!rst_n)
        !$past(en) |-> (!slip_o && !aligned_o));

    a_r7_no_slip_aligned: assert property (@(posedge clk_div) disable iff (!rst_n)
        ($past(aligned_o) && $past(en)) |-> (aligned_o && !slip_o));

    a_r5_slip_on_mismatch: assert property (@(posedge clk_div) disable iff (!rst_n)
        slip_o |-> ($past(en) && !$past(aligned_o) && ($past(watch_bit) != WATCH_VAL)));

endmodule

// File: rtl/deser_align.sv
module deser_align #(
    parameter int   WIDTH     = 6,
    parameter int   WATCH_BIT = 1,
    parameter logic WATCH_VAL = 1'b1,
    parameter int   SLIP_GAP  = 2,
    parameter int   MATCH_N   = 4
) (
    input  logic             clk_fast,
    input  logic             clk_div,
    input  logic             rst_n,
    input  logic             ser_in,
    input  logic             sync_en,
    output logic [WIDTH-1:0] par_out,
    output logic             aligned,
    output logic             bitslip
);

    logic             slip_take;
    logic [WIDTH-1:0] word_fast;
    logic [WIDTH-1:0] par_w;
    logic             slip_w;
    logic             aligned_w;

    deser_slip_xfer u_xfer (
        .clk_fast  (clk_fast),
        .rst_n     (rst_n),
        .slip_div  (slip_w),
        .slip_take (slip_take)
    );

    deser_shift #(.WIDTH(WIDTH)) u_shift (
        .clk_fast  (clk_fast),
        .rst_n     (rst_n),
        .ser_in    (ser_in),
        .slip_take (slip_take),
        .word_o    (word_fast)
    );

    deser_word_out #(.WIDTH(WIDTH)) u_out (
        .clk_div (clk_div),
        .rst_n   (rst_n),
        .word_i  (word_fast),
        .par_o   (par_w)
    );

    deser_align_sync #(
        .WATCH_VAL (WATCH_VAL),
        .SLIP_GAP  (SLIP_GAP),
        .MATCH_N   (MATCH_N)
    ) u_sync (
        .clk_div   (clk_div),
        .rst_n     (rst_n),
        .en        (sync_en),
        .watch_bit (par_w[WATCH_BIT]),
        .slip_o    (slip_w),
        .aligned_o (aligned_w)
    );

    assign par_out = par_w;
    assign aligned = aligned_w;
    assign bitslip = slip_w;

    a_r9_reset_quiet: assert property (@(posedge clk_div)
        !rst_n |-> (par_out == '0 && !aligned && !bitslip));

endmodule

// File: tb/deser_align_tb.sv
module deser_align_tb;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 6;
    localparam int MATCH_N    = 4;
    localparam logic [W-1:0] TRAIN = 6'b000010;
    localparam logic [W-1:0] DA = 6'h2D, DB = 6'h13, DC = 6'h3A;

    logic clk_fast, clk_div, rst_n, ser_in, sync_en;
    logic [W-1:0] par_out;
    logic aligned, bitslip;

    int errors = 0, checks = 0;
    int ph = 0;

    deser_align u_dut (
        .clk_fast (clk_fast), .clk_div (clk_div), .rst_n (rst_n),
        .ser_in (ser_in), .sync_en (sync_en),
        .par_out (par_out), .aligned (aligned), .bitslip (bitslip)
    );

    // both clocks from one generator: divided rising edges fall on fast rising edges
    initial begin
        clk_fast = 1'b1; clk_div = 1'b1;
        forever begin
            #(CLK_PERIOD/2);
            ph       = (ph + 1) % (2*W);
            clk_fast = (ph % 2 == 0);
            clk_div  = (ph < W);
        end
    end

    // serial transmitter, least significant bit first, driven on fast falling edge
    logic [W-1:0] tx_word = TRAIN;
    int bit_idx = 0, data_sel = 0;
    bit tx_data = 0, ins_req = 0, drop_req = 0;

    task automatic adv();
        if (bit_idx == W-1) begin
            bit_idx = 0;
            if (tx_data) begin
                tx_word  = (data_sel == 0) ? DA : (data_sel == 1) ? DB : DC;
                data_sel = (data_sel + 1) % 3;
            end else begin
                tx_word = TRAIN;
            end
        end else begin
            bit_idx++;
        end
    endtask

    always @(negedge clk_fast) begin
        ser_in = tx_word[bit_idx];
        if (ins_req) ins_req = 0;
        else begin
            adv();
            if (drop_req) begin drop_req = 0; adv(); end
        end
    end

    // slip monitor on divided falling edge
    int slip_cnt = 0, cur_run = 0, max_run = 0, idle_run = 0, min_idle = 1000;
    bit had_slip = 0;
    always @(negedge clk_div) begin
        if (rst_n) begin
            if (bitslip) begin
                if (had_slip && idle_run < min_idle) min_idle = idle_run;
                slip_cnt++; cur_run++;
                if (cur_run > max_run) max_run = cur_run;
                idle_run = 0; had_slip = 1;
            end else begin
                cur_run = 0; idle_run++;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_div(input int n);
        for (int i = 0; i < n; i++) @(negedge clk_div);
    endtask

    task automatic wait_aligned(output int cyc);
        cyc = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk_div);
            cyc++;
            if (aligned) break;
        end
    endtask

    task automatic t_reset();
        rst_n = 0; sync_en = 0;
        wait_div(3);
        check(par_out == '0, "R9 par_out in reset", par_out, 0);
        check(!aligned && !bitslip, "R9 flags in reset", {aligned, bitslip}, 0);
        rst_n = 1;
        wait_div(4);
    endtask

    task automatic t_train_from_reset();
        int cyc; int s0;
        s0 = slip_cnt;
        sync_en = 1;
        wait_aligned(cyc);
        check(aligned, "R5 aligned reached", aligned, 1);
        check(slip_cnt - s0 <= W-1, "R5 slips from reset", slip_cnt - s0, W-1);
        wait_div(2);
        check(par_out == TRAIN, "R1 training word", par_out, TRAIN);
    endtask

    task automatic t_data_pass();
        int s0; int found;
        s0 = slip_cnt; found = 0;
        tx_data = 1;
        wait_div(4);
        for (int i = 0; i < 6; i++) begin
            if (par_out == DA) begin found = 1; break; end
            @(negedge clk_div);
        end
        check(found == 1, "R1 data word seen", par_out, DA);
        for (int i = 0; i < 6; i++) begin
            logic [W-1:0] exp;
            exp = (i % 3 == 0) ? DB : (i % 3 == 1) ? DC : DA;
            @(negedge clk_div);
            check(par_out == exp, "R7 data sequence", par_out, exp);
        end
        check(slip_cnt == s0 && aligned, "R7 no slip on data", slip_cnt - s0, 0);
        tx_data = 0;
        wait_div(3);
    endtask

    task automatic t_shift(input bit later, input int exp_slips);
        int cyc; int s0;
        sync_en = 0;
        @(negedge clk_div);
        check(!aligned, "R8 aligned cleared", aligned, 0);
        s0 = slip_cnt;
        if (later) ins_req = 1; else drop_req = 1;
        wait_div(6);
        check(slip_cnt == s0 && !aligned, "R8 no slip while disabled", slip_cnt - s0, 0);
        sync_en = 1;
        wait_aligned(cyc);
        check(aligned, "R2 realigned", aligned, 1);
        check(slip_cnt - s0 == exp_slips, "R2 slip count", slip_cnt - s0, exp_slips);
        wait_div(1);
        check(par_out == TRAIN, "R2 word after realign", par_out, TRAIN);
    endtask

    task automatic t_match_count();
        int cyc; int s0;
        sync_en = 0;
        wait_div(3);
        s0 = slip_cnt;
        sync_en = 1;
        wait_aligned(cyc);
        check(cyc == MATCH_N, "R6 cycles to aligned", cyc, MATCH_N);
        check(slip_cnt == s0, "R6 no slip when aligned", slip_cnt - s0, 0);
    endtask

    task automatic t_pulse_shape();
        check(max_run == 1, "R3 pulse width", max_run, 1);
        check(min_idle >= 2, "R4 idle gap", min_idle, 2);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_train_from_reset();
        t_data_pass();
        t_shift(1'b1, 1);
        t_shift(1'b0, W-1);
        t_match_count();
        t_pulse_shape();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule